// File: doc/BRIEF.md
# Set-Associative Translation Lookup Unit

The block maps a 32-bit virtual address to a physical page address. It uses a small set-associative translation buffer that the block holds itself. Each lookup presents an address, an access kind and the current process identifier. The block answers with a hit flag, the physical page address, the read, write and execute permissions of the matching entry, and a separate flag that says whether the access kind is allowed. A maintenance agent loads entries through a simple one-entry-per-cycle write port. A miss shows only as a low hit flag. Fault raising and table walking belong to other blocks.

Pages are 4 KB, so the page number is address bits [31:12]. The set is taken from the low page-number bits. All ways of that set are compared in parallel, and the lowest-numbered matching way supplies the result. By default the lookup is combinational. A parameter adds one register stage on the outputs.

Top module: `tlb_lookup`

## Requirements
- R1: The page number is `vaddr_i[31:12]`. The set index is the low log2(NUM_SETS) bits of the page number. Entry storage is addressed as way × NUM_SETS + set.
- R2: When `wr_en_i` is high at a rising clock edge, way `wr_way_i` of the set given by the page-number bits of `wr_tag_i` is loaded. The tag word is laid out as page number [31:12], global flag bit 11, valid flag bit 10 and process identifier [PID_W-1:0]. The data fields `wr_pfn_i`, `wr_r_i`, `wr_w_i` and `wr_x_i` are loaded with it. The new entry is visible to lookups from the cycle after that edge. A lookup in the same cycle still sees the old contents.
- R3: A way matches when its valid flag is set, its page number equals the requested page number, and either its global flag is set or its stored process identifier equals `pid_i`.
- R4: When several ways match, the lowest-numbered way supplies the result.
- R5: On a hit, `paddr_o` is the entry's 20-bit frame number shifted left by 12, with the low 12 bits zero. `perm_r_o`, `perm_w_o` and `perm_x_o` are the entry's R, W and X bits.
- R6: On a miss, `hit_o`, `paddr_o`, the three permission outputs and `access_ok_o` are all zero.
- R7: `access_ok_o` is high only on a hit whose permission fits the access kind. Kind 0 (read) needs R, kind 1 (write) needs W, kind 2 (fetch) needs X, and kind 3 is never allowed.
- R8: Reset clears every valid flag, so every lookup misses until an entry is written.
- R9: With REG_OUT = 0 (the default), the outputs follow the lookup inputs in the same cycle. With REG_OUT = 1, they appear one clock later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| vaddr_i | input | 32 | Virtual address to translate |
| acc_type_i | input | 2 | Access kind: 0 read, 1 write, 2 fetch |
| pid_i | input | PID_W | Current process identifier |
| wr_en_i | input | 1 | Entry write strobe |
| wr_way_i | input | WAY_W | Way to load |
| wr_tag_i | input | 32 | Tag word: page number, global, valid, identifier |
| wr_pfn_i | input | 20 | Physical frame number |
| wr_r_i | input | 1 | Read permission bit |
| wr_w_i | input | 1 | Write permission bit |
| wr_x_i | input | 1 | Execute permission bit |
| hit_o | output | 1 | A way matched |
| paddr_o | output | 32 | Physical page address |
| perm_r_o | output | 1 | Entry read permission |
| perm_w_o | output | 1 | Entry write permission |
| perm_x_o | output | 1 | Entry execute permission |
| access_ok_o | output | 1 | Access kind permitted |

## Verification
The hardest case to reach is several ways of one set matching at once, with different reasons for the match. For example, a lower way can fail on its identifier while a higher way matches through its global flag, and two ways can hold the same page with different frames. Uniform random stimulus almost never produces these cases. The bench therefore writes them in directed order, then runs a random phase drawn from only 64 page numbers and 4 identifiers, so that sets fill up and collide often. The same-cycle write case is also directed, and it is sampled before the loading edge.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int PAGE_SHIFT = 12;
  localparam int VPN_W      = 32 - PAGE_SHIFT;
  localparam int PFN_W      = 20;
  localparam int TAG_G_BIT  = 11;
  localparam int TAG_V_BIT  = 10;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_FETCH = 2'd2,
    ACC_NONE  = 2'd3
  } acc_e;

  typedef struct packed {
    logic [PFN_W-1:0] pfn;
    logic             r;
    logic             w;
    logic             x;
  } tlb_data_t;
endpackage

// File: rtl/tlb_store.sv
module tlb_store
  import tlb_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  parameter int PID_W    = 8,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int SLOTS   = NUM_WAYS * NUM_SETS,
  localparam int ENT_W   = VPN_W + 2 + PID_W
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             wr_en_i,
  input  logic [WAY_W-1:0]                 wr_way_i,
  input  logic [31:0]                      wr_tag_i,
  input  tlb_data_t                        wr_data_i,
  input  logic [SET_W-1:0]                 rd_set_i,
  output logic [NUM_WAYS-1:0][ENT_W-1:0]   rd_tag_o,
  output tlb_data_t [NUM_WAYS-1:0]         rd_data_o
);
  // compacted tag: {vpn, global, valid, pid}
  logic [ENT_W-1:0] tag_q  [SLOTS];
  tlb_data_t        data_q [SLOTS];

  logic [SET_W-1:0] wr_set;
  logic [ENT_W-1:0] wr_ent;
  int unsigned      wr_slot;

  assign wr_set  = wr_tag_i[PAGE_SHIFT +: SET_W];
  assign wr_ent  = {wr_tag_i[31:PAGE_SHIFT], wr_tag_i[TAG_G_BIT], wr_tag_i[TAG_V_BIT],
                    wr_tag_i[PID_W-1:0]};
  assign wr_slot = int'(wr_way_i) * NUM_SETS + int'(wr_set);

  generate
    if (PID_W < TAG_V_BIT) begin : g_spare
      logic unused_tag_bits;
      assign unused_tag_bits = ^wr_tag_i[TAG_V_BIT-1:PID_W];
    end
  endgenerate

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < SLOTS; i++) begin
        tag_q[i]  <= '0;
        data_q[i] <= '0;
      end
    end else if (wr_en_i && wr_slot < SLOTS) begin
      tag_q[wr_slot]  <= wr_ent;
      data_q[wr_slot] <= wr_data_i;
    end
  end

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_rd
    assign rd_tag_o[w]  = tag_q[w * NUM_SETS + int'(rd_set_i)];
    assign rd_data_o[w] = data_q[w * NUM_SETS + int'(rd_set_i)];
  end
endmodule

// File: rtl/tlb_way_match.sv
module tlb_way_match
  import tlb_pkg::*;
#(
  parameter int PID_W  = 8,
  localparam int ENT_W = VPN_W + 2 + PID_W
) (
  input  logic [ENT_W-1:0] ent_i,
  input  logic [VPN_W-1:0] vpn_i,
  input  logic [PID_W-1:0] pid_i,
  output logic             match_o
);
  logic [VPN_W-1:0] e_vpn;
  logic             e_g, e_v;
  logic [PID_W-1:0] e_pid;

  assign {e_vpn, e_g, e_v, e_pid} = ent_i;
  assign match_o = e_v && (e_vpn == vpn_i) && (e_g || (e_pid == pid_i));
endmodule

// File: rtl/tlb_pick.sv
module tlb_pick #(
  parameter int NUM_WAYS = 4,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1
) (
  input  logic [NUM_WAYS-1:0] match_i,
  output logic                hit_o,
  output logic [WAY_W-1:0]    way_o
);
  always_comb begin
    way_o = '0;
    for (int w = NUM_WAYS - 1; w >= 0; w--) begin
      if (match_i[w]) way_o = WAY_W'(w);
    end
  end
  assign hit_o = |match_i;
endmodule

// File: rtl/tlb_lookup.sv
module tlb_lookup
  import tlb_pkg::*;
#(
  parameter int NUM_WAYS = 4,
  parameter int NUM_SETS = 16,
  parameter int PID_W    = 8,
  parameter bit REG_OUT  = 1'b0,
  localparam int WAY_W   = (NUM_WAYS > 1) ? $clog2(NUM_WAYS) : 1,
  localparam int SET_W   = $clog2(NUM_SETS),
  localparam int ENT_W   = VPN_W + 2 + PID_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       vaddr_i,
  input  logic [1:0]        acc_type_i,
  input  logic [PID_W-1:0]  pid_i,
  input  logic              wr_en_i,
  input  logic [WAY_W-1:0]  wr_way_i,
  input  logic [31:0]       wr_tag_i,
  input  logic [PFN_W-1:0]  wr_pfn_i,
  input  logic              wr_r_i,
  input  logic              wr_w_i,
  input  logic              wr_x_i,
  output logic              hit_o,
  output logic [31:0]       paddr_o,
  output logic              perm_r_o,
  output logic              perm_w_o,
  output logic              perm_x_o,
  output logic              access_ok_o
);
  logic [VPN_W-1:0]                 vpn;
  logic [NUM_WAYS-1:0][ENT_W-1:0]   rd_tag;
  tlb_data_t [NUM_WAYS-1:0]         rd_data;
  logic [NUM_WAYS-1:0]              match;
  logic                             hit_c;
  logic [WAY_W-1:0]                 way_c;
  tlb_data_t                        sel;
  logic [31:0]                      paddr_c;
  logic                             ok_c;
  logic                             unused_offset;

  assign vpn           = vaddr_i[31:PAGE_SHIFT];
  assign unused_offset = ^vaddr_i[PAGE_SHIFT-1:0];

  tlb_store #(.NUM_WAYS(NUM_WAYS), .NUM_SETS(NUM_SETS), .PID_W(PID_W)) u_store (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_way_i  (wr_way_i),
    .wr_tag_i  (wr_tag_i),
    .wr_data_i ('{pfn: wr_pfn_i, r: wr_r_i, w: wr_w_i, x: wr_x_i}),
    .rd_set_i  (vpn[SET_W-1:0]),
    .rd_tag_o  (rd_tag),
    .rd_data_o (rd_data)
  );

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    tlb_way_match #(.PID_W(PID_W)) u_match (
      .ent_i   (rd_tag[w]),
      .vpn_i   (vpn),
      .pid_i   (pid_i),
      .match_o (match[w])
    );
  end

  tlb_pick #(.NUM_WAYS(NUM_WAYS)) u_pick (
    .match_i (match),
    .hit_o   (hit_c),
    .way_o   (way_c)
  );

  assign sel     = hit_c ? rd_data[way_c] : '0;
  assign paddr_c = {sel.pfn, {PAGE_SHIFT{1'b0}}};

  always_comb begin
    unique case (acc_type_i)
      ACC_READ:  ok_c = sel.r;
      ACC_WRITE: ok_c = sel.w;
      ACC_FETCH: ok_c = sel.x;
      default:   ok_c = 1'b0;
    endcase
  end

  generate
    if (REG_OUT) begin : g_reg
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          hit_o       <= 1'b0;
          paddr_o     <= '0;
          perm_r_o    <= 1'b0;
          perm_w_o    <= 1'b0;
          perm_x_o    <= 1'b0;
          access_ok_o <= 1'b0;
        end else begin
          hit_o       <= hit_c;
          paddr_o     <= paddr_c;
          perm_r_o    <= sel.r;
          perm_w_o    <= sel.w;
          perm_x_o    <= sel.x;
          access_ok_o <= ok_c;
        end
      end
    end else begin : g_comb
      assign hit_o       = hit_c;
      assign paddr_o     = paddr_c;
      assign perm_r_o    = sel.r;
      assign perm_w_o    = sel.w;
      assign perm_x_o    = sel.x;
      assign access_ok_o = ok_c;
    end
  endgenerate
endmodule

// File: rtl/tlb_lookup_chk.sv
module tlb_lookup_chk #(
  parameter int PID_W   = 8,
  parameter bit REG_OUT = 1'b0
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [31:0]      vaddr_i,
  input logic [1:0]       acc_type_i,
  input logic [PID_W-1:0] pid_i,
  input logic             wr_en_i,
  input logic             hit_o,
  input logic [31:0]      paddr_o,
  input logic             perm_r_o,
  input logic             perm_w_o,
  input logic             perm_x_o,
  input logic             access_ok_o
);
  logic any_wr_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) any_wr_q <= 1'b0;
    else if (wr_en_i) any_wr_q <= 1'b1;
  end

  p_empty_miss_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !any_wr_q |-> !hit_o);

  p_miss_quiet_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (paddr_o == 32'd0) && !perm_r_o && !perm_w_o && !perm_x_o && !access_ok_o);

  p_page_aligned_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_o |-> (paddr_o[11:0] == 12'd0));

  p_ok_needs_perm_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    access_ok_o |-> hit_o && (perm_r_o || perm_w_o || perm_x_o));

  generate
    if (!REG_OUT) begin : g_comb_chk
      p_kind3_denied_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (acc_type_i == 2'd3) |-> !access_ok_o);

      p_hold_without_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!$past(wr_en_i) && $stable(vaddr_i) && $stable(pid_i)) |->
          ($stable(hit_o) && $stable(paddr_o)));
    end
  endgenerate
endmodule

bind tlb_lookup tlb_lookup_chk #(.PID_W(PID_W), .REG_OUT(REG_OUT)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .vaddr_i     (vaddr_i),
  .acc_type_i  (acc_type_i),
  .pid_i       (pid_i),
  .wr_en_i     (wr_en_i),
  .hit_o       (hit_o),
  .paddr_o     (paddr_o),
  .perm_r_o    (perm_r_o),
  .perm_w_o    (perm_w_o),
  .perm_x_o    (perm_x_o),
  .access_ok_o (access_ok_o)
);

// File: tb/tlb_lookup_bench.sv
module tlb_lookup_bench;
  localparam int WAYS  = 4;
  localparam int SETS  = 16;
  localparam int PID_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [31:0]      vaddr = '0;
  logic [1:0]       acc = '0;
  logic [PID_W-1:0] pid = '0;
  logic             wr_en = 1'b0;
  logic [1:0]       wr_way = '0;
  logic [31:0]      wr_tag = '0;
  logic [19:0]      wr_pfn = '0;
  logic             wr_r = 1'b0, wr_w = 1'b0, wr_x = 1'b0;
  logic             hit, pr, pw, px, ok;
  logic [31:0]      paddr;

  int checks = 0;
  int errors = 0;

  // behavioural model storage
  int m_vpn [WAYS][SETS];
  int m_pid [WAYS][SETS];
  int m_pfn [WAYS][SETS];
  bit m_g [WAYS][SETS], m_v [WAYS][SETS];
  bit m_r [WAYS][SETS], m_w [WAYS][SETS], m_x [WAYS][SETS];

  always #5 clk = ~clk;

  tlb_lookup #(.NUM_WAYS(WAYS), .NUM_SETS(SETS), .PID_W(PID_W)) u_tlb_lookup (
    .clk_i(clk), .rst_ni(rst_n), .vaddr_i(vaddr), .acc_type_i(acc), .pid_i(pid),
    .wr_en_i(wr_en), .wr_way_i(wr_way), .wr_tag_i(wr_tag), .wr_pfn_i(wr_pfn),
    .wr_r_i(wr_r), .wr_w_i(wr_w), .wr_x_i(wr_x),
    .hit_o(hit), .paddr_o(paddr), .perm_r_o(pr), .perm_w_o(pw), .perm_x_o(px),
    .access_ok_o(ok)
  );

  task automatic model_clear();
    for (int w = 0; w < WAYS; w++)
      for (int s = 0; s < SETS; s++) begin
        m_v[w][s] = 0; m_g[w][s] = 0; m_vpn[w][s] = 0; m_pid[w][s] = 0;
        m_pfn[w][s] = 0; m_r[w][s] = 0; m_w[w][s] = 0; m_x[w][s] = 0;
      end
  endtask

  task automatic check(input string tag);
    int vp, s, hw;
    bit e_hit, e_ok, e_r, e_w, e_x;
    logic [31:0] e_pa;
    vp = int'(vaddr >> 12);
    s  = vp % SETS;
    hw = -1;
    for (int w = WAYS - 1; w >= 0; w--)
      if (m_v[w][s] && m_vpn[w][s] == vp && (m_g[w][s] || m_pid[w][s] == int'(pid))) hw = w;
    e_hit = (hw >= 0);
    e_pa = 0; e_r = 0; e_w = 0; e_x = 0;
    if (e_hit) begin
      e_pa = 32'(m_pfn[hw][s]) << 12;
      e_r = m_r[hw][s]; e_w = m_w[hw][s]; e_x = m_x[hw][s];
    end
    case (acc)
      2'd0: e_ok = e_r;
      2'd1: e_ok = e_w;
      2'd2: e_ok = e_x;
      default: e_ok = 0;
    endcase
    checks++;
    if (hit !== e_hit || paddr !== e_pa || pr !== e_r || pw !== e_w || px !== e_x || ok !== e_ok) begin
      errors++;
      $display("FAIL %s va=%h pid=%0d acc=%0d act hit=%b pa=%h rwx=%b%b%b ok=%b exp hit=%b pa=%h rwx=%b%b%b ok=%b",
               tag, vaddr, pid, acc, hit, paddr, pr, pw, px, ok, e_hit, e_pa, e_r, e_w, e_x, e_ok);
    end
  endtask

  // one clock: model follows write at the edge, compare at the falling edge
  task automatic step(input string tag);
    @(posedge clk);
    if (wr_en) begin
      int s, w;
      s = int'(wr_tag >> 12) % SETS;
      w = int'(wr_way);
      m_vpn[w][s] = int'(wr_tag >> 12); m_g[w][s] = wr_tag[11]; m_v[w][s] = wr_tag[10];
      m_pid[w][s] = int'(wr_tag[PID_W-1:0]); m_pfn[w][s] = int'(wr_pfn);
      m_r[w][s] = wr_r; m_w[w][s] = wr_w; m_x[w][s] = wr_x;
    end
    @(negedge clk);
    check(tag);
  endtask

  task automatic put(input int way, input int vp, input bit g, input bit v, input int p,
                     input int pfn, input bit r, input bit w, input bit x);
    wr_en = 1; wr_way = 2'(way);
    wr_tag = {20'(vp), g, v, 2'b00, 8'(p)};
    wr_pfn = 20'(pfn); wr_r = r; wr_w = w; wr_x = x;
    step("R2 write");
    wr_en = 0;
  endtask

  task automatic look(input int vp, input int p, input int a, input string tag);
    vaddr = {20'(vp), 12'h5A5}; pid = PID_W'(p); acc = 2'(a);
    step(tag);
  endtask

  initial begin
    int ticks = 0;
    while (ticks < 100000) begin @(posedge clk); ticks++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(negedge clk);
    check("R8 in reset");
    rst_n = 1;
    look(0, 0, 0, "R8 vpn0 after reset");
    look(32'h13, 5, 0, "R8 empty");

    put(0, 32'h00013, 0, 1, 5, 32'hABCDE, 1, 0, 0);
    look(32'h13, 5, 0, "R3 pid match read R5 R7");
    look(32'h13, 5, 1, "R7 write denied");
    look(32'h13, 5, 3, "R7 kind3");
    look(32'h13, 6, 0, "R3 pid mismatch R6");
    look(32'h23, 5, 0, "R1 same set other vpn miss");

    put(1, 32'h00023, 1, 1, 0, 32'h11111, 0, 1, 1);
    look(32'h23, 77, 1, "R3 global any pid");
    look(32'h23, 3, 2, "R7 fetch on global");

    put(0, 32'h00045, 0, 1, 9, 32'h22222, 1, 1, 0);
    put(1, 32'h00045, 1, 1, 0, 32'h33333, 0, 0, 1);
    look(32'h45, 2, 2, "R4 lower way pid miss, global way1");
    look(32'h45, 9, 0, "R4 way0 wins");

    put(2, 32'h00067, 0, 1, 4, 32'h44444, 1, 0, 0);
    put(3, 32'h00067, 0, 1, 4, 32'h55555, 0, 1, 0);
    look(32'h67, 4, 0, "R4 way2 over way3");

    put(2, 32'h00018, 1, 0, 0, 32'h66666, 1, 1, 1);
    look(32'h18, 0, 0, "R3 invalid entry miss");

    // same-cycle write is not yet visible
    vaddr = 32'h0007_9000; pid = 8'd1; acc = 2'd0;
    wr_en = 1; wr_way = 2'd3; wr_tag = {20'h00079, 1'b0, 1'b1, 2'b00, 8'd1};
    wr_pfn = 20'h77777; wr_r = 1; wr_w = 0; wr_x = 0;
    #2 check("R2 old contents in write cycle");
    step("R2 visible next cycle");
    wr_en = 0;
    look(32'h79, 1, 0, "R2 entry loaded");

    for (int i = 0; i < 3000; i++) begin
      wr_en  = ($urandom % 3) == 0;
      wr_way = 2'($urandom);
      wr_tag = {20'($urandom % 64), 1'($urandom % 4 == 0), 1'($urandom % 8 != 0), 2'b00,
                8'($urandom % 4)};
      wr_pfn = 20'($urandom); wr_r = 1'($urandom); wr_w = 1'($urandom); wr_x = 1'($urandom);
      vaddr  = {20'($urandom % 64), 12'($urandom)};
      pid    = PID_W'($urandom % 4);
      acc    = 2'($urandom);
      step("R1 R3 R4 R5 R6 R7 random");
    end
    wr_en = 0;

    rst_n = 0;
    model_clear();
    @(negedge clk);
    rst_n = 1;
    look(32'h79, 1, 0, "R8 cleared by reset");
    look(32'h13, 5, 0, "R8 cleared by reset 2");
    look(32'h23, 0, 0, "R9 comb outputs");

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule